// File: doc/BRIEF.md
# Windowed Register File Trap Entry Sequencer

This block carries out the hardware side of taking a trap on a processor whose integer registers are organised as rotating windows. When a trap request arrives with an 8-bit trap type, the block captures the processor state that the request presents. It then moves to the previous window, modulo the window count. It stores the interrupted program counter and next program counter into two local registers of that window, one per cycle, through a single register-file write port.

In the last cycle it presents the updated processor state together with a commit strobe and a done pulse. The state it presents covers four things:
- The new window pointer.
- Traps disabled.
- The supervisor bit set, with the old supervisor bit kept as the previous-supervisor bit.
- A trap base value in which the trap type replaces bits 11:4. The two new program counters are derived from this value.

A trap that arrives while traps are already disabled does not enter. Instead the block locks into an error state that only reset clears.

Top module: `trap_entry_seq`

## Requirements
- R1: During and right after reset the block is idle: busy, error, rf_we, state_we and done are all 0.
- R2: In the cycle after a request is accepted with et_in=1, rf_we is 1 and the block writes pc_in to register number 17 (local register 1; locals are registers 16 to 23) of window (cwp_in - 1) mod NWIN. Window 0 wraps to window NWIN-1.
- R3: In the next cycle the block writes npc_in to register number 18 (local register 2) of the same window.
- R4: In the third cycle after acceptance, state_we and done are 1 for exactly one cycle, and new_cwp equals (cwp_in - 1) mod NWIN.
- R5: In the commit cycle new_et is 0, new_s is 1, and new_ps equals the s_in captured with the request.
- R6: new_tbr keeps tbr_in[31:12], carries the trap type in bits 11:4 and has bits 3:0 at 0. new_pc equals new_tbr, and new_npc equals new_tbr + 4.
- R7: busy is 1 for the three sequence cycles. A trap_req seen while busy, including in the done cycle, is ignored. A request still present in the first idle cycle is accepted.
- R8: A request accepted while et_in=0 sets error from the next cycle until reset. In that state there are no register writes, no commit and no done, and further requests are ignored.
- R9: All values written or committed are those present on the inputs in the accepting cycle. Later changes to the inputs have no effect.
- R10: The register-file port writes at most one register per cycle, and exactly two per trap entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request, sampled when idle |
| trap_type | input | 8 | Trap type code |
| pc_in | input | 32 | Current program counter |
| npc_in | input | 32 | Current next program counter |
| cwp_in | input | 3 | Current window pointer |
| et_in | input | 1 | Traps-enabled bit |
| s_in | input | 1 | Supervisor bit |
| tbr_in | input | 32 | Trap base register |
| busy | output | 1 | Sequence in progress |
| error | output | 1 | Trap taken while traps disabled |
| rf_we | output | 1 | Register-file write enable |
| rf_win | output | 3 | Window of the write |
| rf_reg | output | 5 | Register number within the window |
| rf_wdata | output | 32 | Write data |
| state_we | output | 1 | Commit strobe for the new state |
| done | output | 1 | End-of-sequence pulse |
| new_cwp | output | 3 | New window pointer |
| new_et | output | 1 | New traps-enabled bit |
| new_s | output | 1 | New supervisor bit |
| new_ps | output | 1 | New previous-supervisor bit |
| new_tbr | output | 32 | New trap base register |
| new_pc | output | 32 | New program counter |
| new_npc | output | 32 | New next program counter |

## Verification
The request input and the end of a sequence can meet in one cycle: the done cycle of one trap can coincide with a trap_req that must be ignored. The bench holds trap_req high through a whole sequence and past it. The behavioural model then expects the done pulse without a second capture, and a fresh acceptance in the first idle cycle after it. Acceptance and the traps-disabled check also meet in a single cycle. This is provoked by requesting with et_in low, right after a completed entry and again after reset. Every output is compared against the model on every clock.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int TT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trap_req,
  input  logic [TT_W-1:0]          trap_type,
  input  logic [XLEN-1:0]          pc_in,
  input  logic [XLEN-1:0]          npc_in,
  input  logic [$clog2(NWIN)-1:0]  cwp_in,
  input  logic                     et_in,
  input  logic                     s_in,
  input  logic [XLEN-1:0]          tbr_in,
  output logic                     busy,
  output logic                     error,
  output logic                     rf_we,
  output logic [$clog2(NWIN)-1:0]  rf_win,
  output logic [4:0]               rf_reg,
  output logic [XLEN-1:0]          rf_wdata,
  output logic                     state_we,
  output logic                     done,
  output logic [$clog2(NWIN)-1:0]  new_cwp,
  output logic                     new_et,
  output logic                     new_s,
  output logic                     new_ps,
  output logic [XLEN-1:0]          new_tbr,
  output logic [XLEN-1:0]          new_pc,
  output logic [XLEN-1:0]          new_npc
);
  localparam int CW = $clog2(NWIN);
  localparam logic [4:0] REG_PC  = 5'd17;
  localparam logic [4:0] REG_NPC = 5'd18;
  localparam int TT_LO = 4;
  localparam int BASE_LO = TT_LO + TT_W;

  typedef enum logic [2:0] {S_IDLE, S_WPC, S_WNPC, S_FIN, S_ERR} st_t;

  st_t st;
  logic [TT_W-1:0] tt_q;
  logic [XLEN-1:0] pc_q, npc_q, tbr_q;
  logic [CW-1:0]   win_q;
  logic            s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tt_q  <= '0;
      pc_q  <= '0;
      npc_q <= '0;
      tbr_q <= '0;
      win_q <= '0;
      s_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (trap_req) begin
          tt_q  <= trap_type;
          pc_q  <= pc_in;
          npc_q <= npc_in;
          tbr_q <= tbr_in;
          win_q <= cwp_in - 1'b1;
          s_q   <= s_in;
          st    <= et_in ? S_WPC : S_ERR;
        end
        S_WPC:   st <= S_WNPC;
        S_WNPC:  st <= S_FIN;
        S_FIN:   st <= S_IDLE;
        default: st <= S_ERR;
      endcase
    end
  end

  assign busy     = (st == S_WPC) || (st == S_WNPC) || (st == S_FIN);
  assign error    = (st == S_ERR);
  assign rf_we    = (st == S_WPC) || (st == S_WNPC);
  assign rf_win   = win_q;
  assign rf_reg   = (st == S_WNPC) ? REG_NPC : REG_PC;
  assign rf_wdata = (st == S_WNPC) ? npc_q : pc_q;
  assign state_we = (st == S_FIN);
  assign done     = (st == S_FIN);
  assign new_cwp  = win_q;
  assign new_et   = 1'b0;
  assign new_s    = 1'b1;
  assign new_ps   = s_q;
  assign new_tbr  = {tbr_q[XLEN-1:BASE_LO], tt_q, {TT_LO{1'b0}}};
  assign new_pc   = new_tbr;
  assign new_npc  = new_tbr + XLEN'(4);
endmodule

module trap_entry_seq_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    error,
  input logic                    rf_we,
  input logic [$clog2(NWIN)-1:0] rf_win,
  input logic [4:0]              rf_reg,
  input logic                    state_we,
  input logic                    done,
  input logic [$clog2(NWIN)-1:0] new_cwp,
  input logic                    new_et,
  input logic                    new_s,
  input logic [XLEN-1:0]         new_pc,
  input logic [XLEN-1:0]         new_npc
);
  AST_PC_THEN_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_reg == 5'd17) |=> (rf_we && rf_reg == 5'd18 && $stable(rf_win))); // R3
  AST_NPC_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_reg == 5'd18) |=> (done && state_we)); // R4
  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_we && !rf_we)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R7
  AST_CWP_MATCHES_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_cwp == $past(rf_win))); // R4
  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> (new_s && !new_et)); // R5
  AST_VECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> (new_pc[3:0] == 4'h0 && new_npc[3:0] == 4'h4)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!rf_we && !done && !busy)); // R8
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .error(error), .rf_we(rf_we),
  .rf_win(rf_win), .rf_reg(rf_reg), .state_we(state_we), .done(done),
  .new_cwp(new_cwp), .new_et(new_et), .new_s(new_s), .new_pc(new_pc),
  .new_npc(new_npc)
);

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0;
  logic [7:0] trap_type = '0;
  logic [31:0] pc_in = '0, npc_in = '0, tbr_in = '0;
  logic [2:0] cwp_in = '0;
  logic et_in = 1'b0, s_in = 1'b0;
  logic busy, error, rf_we, state_we, done, new_et, new_s, new_ps;
  logic [2:0] rf_win, new_cwp;
  logic [4:0] rf_reg;
  logic [31:0] rf_wdata, new_tbr, new_pc, new_npc;

  int checks = 0, errors = 0;
  int phase = 0;
  logic [7:0]  m_tt;
  logic [31:0] m_pc, m_npc, m_tbr;
  logic [2:0]  m_win;
  logic        m_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .pc_in(pc_in), .npc_in(npc_in), .cwp_in(cwp_in), .et_in(et_in),
    .s_in(s_in), .tbr_in(tbr_in), .busy(busy), .error(error), .rf_we(rf_we),
    .rf_win(rf_win), .rf_reg(rf_reg), .rf_wdata(rf_wdata), .state_we(state_we),
    .done(done), .new_cwp(new_cwp), .new_et(new_et), .new_s(new_s),
    .new_ps(new_ps), .new_tbr(new_tbr), .new_pc(new_pc), .new_npc(new_npc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 pc write, 2 npc write, 3 commit, 4 error
  always @(posedge clk) begin
    if (!rst_n) phase = 0;
    else case (phase)
      0: if (trap_req) begin
        m_tt = trap_type; m_pc = pc_in; m_npc = npc_in; m_tbr = tbr_in; m_s = s_in;
        m_win = 3'((int'(cwp_in) + NWIN - 1) % NWIN);
        phase = et_in ? 1 : 4;
      end
      1: phase = 2;
      2: phase = 3;
      3: phase = 0;
      default: phase = 4;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] vec;
      chk("R10 rf_we", 32'(rf_we), 32'(phase == 1 || phase == 2));
      chk("R7 busy", 32'(busy), 32'(phase >= 1 && phase <= 3));
      chk("R8 error", 32'(error), 32'(phase == 4));
      chk("R4 done", 32'(done), 32'(phase == 3));
      chk("R4 state_we", 32'(state_we), 32'(phase == 3));
      if (phase == 1) begin
        chk("R2 window", 32'(rf_win), 32'(m_win));
        chk("R2 reg", 32'(rf_reg), 32'd17);
        chk("R2 R9 pc data", rf_wdata, m_pc);
      end
      if (phase == 2) begin
        chk("R3 window", 32'(rf_win), 32'(m_win));
        chk("R3 reg", 32'(rf_reg), 32'd18);
        chk("R3 R9 npc data", rf_wdata, m_npc);
      end
      if (phase == 3) begin
        vec = {m_tbr[31:12], m_tt, 4'h0};
        chk("R4 new_cwp", 32'(new_cwp), 32'(m_win));
        chk("R5 new_et", 32'(new_et), 32'd0);
        chk("R5 new_s", 32'(new_s), 32'd1);
        chk("R5 new_ps", 32'(new_ps), 32'(m_s));
        chk("R6 new_tbr", new_tbr, vec);
        chk("R6 new_pc", new_pc, vec);
        chk("R6 new_npc", new_npc, vec + 32'd4);
      end
    end
  end

  task automatic trap(input logic [7:0] tt, input logic [31:0] pc, input logic [2:0] cwp,
                      input logic s, input logic et, input logic [31:0] tbr, input int hold);
    @(negedge clk);
    trap_type = tt; pc_in = pc; npc_in = pc + 32'd4; cwp_in = cwp;
    s_in = s; et_in = et; tbr_in = tbr; trap_req = 1'b1;
    @(negedge clk);
    // R9: disturb inputs after capture
    pc_in = ~pc; npc_in = 32'h0BAD_F00D; cwp_in = cwp + 3'd3; s_in = ~s; tbr_in = ~tbr;
    trap_type = ~tt;
    for (int i = 1; i < hold; i++) @(negedge clk);
    trap_req = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 error in reset", 32'(error), 32'd0);
        chk("R1 rf_we in reset", 32'(rf_we), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state_we after reset", 32'(state_we), 32'd0);
        trap(8'h11, 32'h4000_1000, 3'd5, 1'b0, 1'b1, 32'hF000_0ABC, 1);
        trap(8'hFF, 32'h0000_2004, 3'd0, 1'b1, 1'b1, 32'h1234_5FFF, 1); // R2 wrap
        trap(8'h00, 32'h8000_0008, 3'd7, 1'b1, 1'b1, 32'hFFFF_FFFF, 1);
        trap(8'h5A, 32'h0001_0000, 3'd1, 1'b0, 1'b1, 32'h0000_0000, 6); // R7 held request
        trap(8'h80, 32'hDEAD_BEE0, 3'd2, 1'b1, 1'b1, 32'hA5A5_A000, 4); // R7 request in done cycle
        trap(8'h33, 32'h1111_1110, 3'd3, 1'b1, 1'b0, 32'h2222_2000, 3); // R8
        repeat (4) @(negedge clk);
        chk("R8 error sticky", 32'(error), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 error cleared by reset", 32'(error), 32'd0);
        trap(8'h7E, 32'h0000_0400, 3'd4, 1'b0, 1'b1, 32'h0040_0000, 1);
        trap(8'h01, 32'h0000_0800, 3'd6, 1'b1, 1'b0, 32'h0080_0000, 1); // R8 after entry
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule